// File: doc/BRIEF.md
# Peripheral Clock-Gate and Reset Controller

This block holds the clock-enable and reset-hold levels for the peripherals of a chip. The peripherals fall into three groups: the main interconnect, the fast bridge and the slow bridge, each with up to 16 lines. Software reaches the block through a small 16-bit register port with an address, a write strobe, a read strobe and write/read data. The outputs are plain level signals: one clock enable and one reset hold per line. The clock cells that consume them sit elsewhere.

Clock enables use a pair of write-one-to-set and write-one-to-clear registers. A driver can then switch one line without a read-modify-write. Each line has a fixed role, chosen by parameter masks:
- A software line follows the set and clear registers.
- A hardware-owned line follows a request input and ignores software.
- A line without an enable bit is always on.
- The protected console line can be set but never cleared.

Reset holds use one plain read/write register per group.

Top module: `periph_gate_ctrl`

## Requirements
- R1: A write to a group's set register (address group*4+2) turns on every software line whose data bit is 1, from the clock edge that samples the write. Lines whose data bit is 0 keep their state.
- R2: A write to a group's clear register (address group*4+3) turns off every software line whose data bit is 1. Lines whose data bit is 0 keep their state.
- R3: A set or clear write with several data bits high changes all of those lines at the same clock edge.
- R4: Hardware-owned lines ignore set and clear writes. Their enable follows the matching bit of `hwClkReq` in the same cycle. The default hardware-owned lines are interconnect bits 3 and 4, fast bit 0 and slow bit 0.
- R5: Lines without an enable bit always drive a 1 and read back as 1. The defaults are interconnect bit 12 and slow bit 6.
- R6: The protected console line (default slow bit 1) comes out of reset enabled. A clear-register write never turns it off.
- R7: Each group's reset register (address group*4+0) is written whole with a 16-bit write and reads back its current value. A 1 bit holds that peripheral in reset and drives its `periphRst` bit high.
- R8: After reset every reset bit is 1. Every software line is off, except the protected line.
- R9: Reading a group's status address (group*4+1) returns that group's current effective clock enables, one bit per line.
- R10: Reads of addresses 12 to 15, and of any set or clear address, return 0. Writes to addresses 12 to 15, or to a status address, change nothing.
- R11: `rdData` takes the read value at the clock edge that samples `rdEn`, and holds it until the next read.

Groups 0, 1 and 2 are the interconnect, fast and slow groups. In `clkEn` and `periphRst`, bit group*16+line belongs to that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 16 | Write data |
| hwClkReq | input | 48 | Enable requests for hardware-owned lines |
| rdData | output | 16 | Registered read data |
| clkEn | output | 48 | Per-line clock enables |
| periphRst | output | 48 | Per-line reset holds |

## Verification
A write changes `clkEn` or `periphRst` at the rising edge that samples `wrEn`. A read result lands on `rdData` at the edge that samples `rdEn`. A change on `hwClkReq` reaches `clkEn` without any register in between. The bench drives every input on the falling edge and samples on the following falling edge, so each result is checked half a cycle after the edge that is due to produce it. Read results are compared by a monitor that pops the expected value, queued by the read task, on the falling edge after the read strobe was taken.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  localparam int GRP_IDX_W = 4;

  typedef enum logic [1:0] {
    OFS_RST  = 2'd0,
    OFS_STAT = 2'd1,
    OFS_SET  = 2'd2,
    OFS_CLR  = 2'd3
  } regOfs_t;

  typedef struct packed {
    logic                 wrRst;
    logic                 wrSet;
    logic                 wrClr;
    logic                 rdStb;
    logic                 rdHit;
    logic                 rdStat;
    logic [GRP_IDX_W-1:0] grp;
  } strobe_t;

endpackage

// File: rtl/pgc_decode.sv
module pgc_decode #(
  parameter int GROUPS = 3,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output pgc_pkg::strobe_t  stb
);
  import pgc_pkg::*;

  localparam int GRP_BITS = ADDR_W - 2;

  logic [GRP_BITS-1:0] grpIdx;
  regOfs_t             ofs;
  logic                inMap;

  always_comb begin
    grpIdx     = addr[ADDR_W-1:2];
    ofs        = regOfs_t'(addr[1:0]);
    inMap      = int'(grpIdx) < GROUPS;
    stb.grp    = GRP_IDX_W'(grpIdx);
    stb.wrRst  = wrEn && inMap && (ofs == OFS_RST);
    stb.wrSet  = wrEn && inMap && (ofs == OFS_SET);
    stb.wrClr  = wrEn && inMap && (ofs == OFS_CLR);
    stb.rdStb  = rdEn;
    stb.rdHit  = inMap && ((ofs == OFS_RST) || (ofs == OFS_STAT));
    stb.rdStat = (ofs == OFS_STAT);
  end

endmodule

// File: rtl/pgc_regs.sv
module pgc_regs #(
  parameter int                        GROUPS      = 3,
  parameter int                        LINES       = 16,
  parameter logic [GROUPS*LINES-1:0]   HW_MASK     = '0,
  parameter logic [GROUPS*LINES-1:0]   ABSENT_MASK = '0,
  parameter logic [GROUPS*LINES-1:0]   PROT_MASK   = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pgc_pkg::strobe_t          stb,
  input  logic [LINES-1:0]          wrData,
  input  logic [GROUPS*LINES-1:0]   hwClkReq,
  output logic [GROUPS*LINES-1:0]   clkEn,
  output logic [GROUPS*LINES-1:0]   periphRst,
  output logic [LINES-1:0]          rdData
);

  logic [LINES-1:0] grpEn  [GROUPS];
  logic [LINES-1:0] grpRst [GROUPS];
  logic [LINES-1:0] rdNext;

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    localparam logic [LINES-1:0] HwM   = HW_MASK[g*LINES +: LINES];
    localparam logic [LINES-1:0] AbsM  = ABSENT_MASK[g*LINES +: LINES];
    localparam logic [LINES-1:0] ProtM = PROT_MASK[g*LINES +: LINES];
    localparam logic [LINES-1:0] SwM   = ~(HwM | AbsM);

    logic [LINES-1:0] swEn;
    logic [LINES-1:0] rstReg;
    logic             sel;

    assign sel = (int'(stb.grp) == g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swEn   <= ProtM & SwM;
        rstReg <= '1;
      end else begin
        if (stb.wrRst && sel) rstReg <= wrData;
        if (stb.wrSet && sel)
          swEn <= swEn | (wrData & SwM);
        else if (stb.wrClr && sel)
          swEn <= swEn & ~(wrData & SwM & ~ProtM);
      end
    end

    assign grpEn[g]  = (swEn & SwM) | (hwClkReq[g*LINES +: LINES] & HwM) | AbsM;
    assign grpRst[g] = rstReg;
    assign clkEn[g*LINES +: LINES]     = grpEn[g];
    assign periphRst[g*LINES +: LINES] = rstReg;
  end

  always_comb begin
    rdNext = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (stb.rdHit && (int'(stb.grp) == g))
        rdNext = stb.rdStat ? grpEn[g] : grpRst[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl #(
  parameter int                      GROUPS      = 3,
  parameter int                      LINES       = 16,
  parameter int                      ADDR_W      = 4,
  parameter logic [GROUPS*LINES-1:0] HW_MASK     = {16'h0001, 16'h0001, 16'h0018},
  parameter logic [GROUPS*LINES-1:0] ABSENT_MASK = {16'h0040, 16'h0000, 16'h1000},
  parameter logic [GROUPS*LINES-1:0] PROT_MASK   = {16'h0002, 16'h0000, 16'h0000}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [LINES-1:0]        wrData,
  input  logic [GROUPS*LINES-1:0] hwClkReq,
  output logic [LINES-1:0]        rdData,
  output logic [GROUPS*LINES-1:0] clkEn,
  output logic [GROUPS*LINES-1:0] periphRst
);

  pgc_pkg::strobe_t stb;

  pgc_decode #(.GROUPS(GROUPS), .ADDR_W(ADDR_W)) i_decode (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  pgc_regs #(
    .GROUPS      (GROUPS),
    .LINES       (LINES),
    .HW_MASK     (HW_MASK),
    .ABSENT_MASK (ABSENT_MASK),
    .PROT_MASK   (PROT_MASK)
  ) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .hwClkReq  (hwClkReq),
    .clkEn     (clkEn),
    .periphRst (periphRst),
    .rdData    (rdData)
  );

endmodule

// File: rtl/periph_gate_ctrl_chk.sv
module periph_gate_ctrl_chk #(
  parameter int                      GROUPS      = 3,
  parameter int                      LINES       = 16,
  parameter int                      ADDR_W      = 4,
  parameter logic [GROUPS*LINES-1:0] HW_MASK     = '0,
  parameter logic [GROUPS*LINES-1:0] ABSENT_MASK = '0,
  parameter logic [GROUPS*LINES-1:0] PROT_MASK   = '0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       addr,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [LINES-1:0]        wrData,
  input logic [GROUPS*LINES-1:0] hwClkReq,
  input logic [LINES-1:0]        rdData,
  input logic [GROUPS*LINES-1:0] clkEn,
  input logic [GROUPS*LINES-1:0] periphRst
);

  logic rstWrite;
  logic outOfMap;
  assign rstWrite = wrEn && (addr[1:0] == 2'd0) && (int'(addr[ADDR_W-1:2]) < GROUPS);
  assign outOfMap = int'(addr[ADDR_W-1:2]) >= GROUPS;

  // R7: reset holds move only on a write to a reset register
  a_r7_rst_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !rstWrite |=> $stable(periphRst));

  // R4: hardware-owned lines track their request input
  a_r4_hw_follow: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn & HW_MASK) == (hwClkReq & HW_MASK));

  // R5: lines without an enable bit stay on
  a_r5_absent_on: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn & ABSENT_MASK) == ABSENT_MASK);

  // R6: protected console line is never off
  a_r6_console_kept: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn & PROT_MASK) == PROT_MASK);

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && outOfMap) |=> (rdData == '0));

  // R11: read data holds without a read strobe
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  for (genvar g = 0; g < GROUPS; g++) begin : gChk
    localparam logic [LINES-1:0] SwM =
      ~(HW_MASK[g*LINES +: LINES] | ABSENT_MASK[g*LINES +: LINES]);
    localparam logic [LINES-1:0] ClrM = SwM & ~PROT_MASK[g*LINES +: LINES];

    // R1 / R3: every set bit lands in one edge
    a_r1_set_lines: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(g*4 + 2)) |=>
        ((clkEn[g*LINES +: LINES] & $past(wrData) & SwM) == ($past(wrData) & SwM)));

    // R2 / R3: every cleared bit drops in one edge
    a_r2_clear_lines: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(g*4 + 3)) |=>
        ((clkEn[g*LINES +: LINES] & $past(wrData) & ClrM) == '0));
  end

endmodule

bind periph_gate_ctrl periph_gate_ctrl_chk #(
  .GROUPS      (GROUPS),
  .LINES       (LINES),
  .ADDR_W      (ADDR_W),
  .HW_MASK     (HW_MASK),
  .ABSENT_MASK (ABSENT_MASK),
  .PROT_MASK   (PROT_MASK)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .wrData    (wrData),
  .hwClkReq  (hwClkReq),
  .rdData    (rdData),
  .clkEn     (clkEn),
  .periphRst (periphRst)
);

// File: tb/test_periph_gate_ctrl.sv
module test_periph_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] HW  = {16'h0001, 16'h0001, 16'h0018};
  localparam logic [47:0] ABS = {16'h0040, 16'h0000, 16'h1000};
  localparam logic [47:0] PRT = {16'h0002, 16'h0000, 16'h0000};

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  addr = '0;
  logic        wrEn = 0;
  logic        rdEn = 0;
  logic [15:0] wrData = '0;
  logic [47:0] hwClkReq = '0;
  logic [15:0] rdData;
  logic [47:0] clkEn;
  logic [47:0] periphRst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mSw  [3];
  logic [15:0] mRst [3];
  logic [15:0] expQ [$];
  string       tagQ [$];
  logic        rdSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_gate_ctrl i_periph_gate_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .hwClkReq(hwClkReq), .rdData(rdData),
    .clkEn(clkEn), .periphRst(periphRst)
  );

  function automatic logic [15:0] swMask(int g);
    return ~(HW[g*16 +: 16] | ABS[g*16 +: 16]);
  endfunction

  function automatic logic [15:0] expStat(int g);
    return (mSw[g] & swMask(g)) | (hwClkReq[g*16 +: 16] & HW[g*16 +: 16]) | ABS[g*16 +: 16];
  endfunction

  function automatic logic [47:0] expClk();
    return {expStat(2), expStat(1), expStat(0)};
  endfunction

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    if (int'(a[3:2]) < 3) begin
      case (a[1:0])
        2'd0: mRst[a[3:2]] = d;
        2'd2: mSw[a[3:2]]  = mSw[a[3:2]] | (d & swMask(int'(a[3:2])));
        2'd3: mSw[a[3:2]]  = mSw[a[3:2]] & ~(d & swMask(int'(a[3:2])) & ~PRT[a[3:2]*16 +: 16]);
        default: ;
      endcase
    end
  endtask

  task automatic rd(logic [3:0] a, string tag);
    logic [15:0] e;
    e = '0;
    if (int'(a[3:2]) < 3) begin
      if (a[1:0] == 2'd0) e = mRst[a[3:2]];
      else if (a[1:0] == 2'd1) e = expStat(int'(a[3:2]));
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    addr = a; rdEn = 1;
    @(negedge clk);
    rdEn = 0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(t, {32'h0, rdData}, {32'h0, e});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    for (int g = 0; g < 3; g++) begin
      mSw[g]  = PRT[g*16 +: 16] & swMask(g);
      mRst[g] = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R8 reset state
    chk("R8 periphRst after reset", periphRst, 48'hFFFF_FFFF_FFFF);
    chk("R8 clkEn after reset", clkEn, expClk());
    for (int g = 0; g < 3; g++) rd(4'(g*4), "R8 reset reg readback");
    for (int g = 0; g < 3; g++) rd(4'(g*4 + 1), "R9 status after reset");

    // R7 reset register write and readback
    wr(4'd4, 16'h00F0);
    chk("R7 periphRst fast group", periphRst, {16'hFFFF, 16'h00F0, 16'hFFFF});
    rd(4'd4, "R7 reset reg readback");
    wr(4'd8, 16'hA5A5);
    rd(4'd8, "R7 slow reset readback");

    // R1 single set
    wr(4'd2, 16'h0005);
    chk("R1 set interconnect lines", clkEn, expClk());
    rd(4'd1, "R1 status readback");

    // R3 multi-bit set and clear
    wr(4'd10, 16'h0F00);
    chk("R3 multi set slow", clkEn, expClk());
    wr(4'd6, 16'hFFFE);
    chk("R3 multi set fast", clkEn, expClk());

    // R2 clear leaves others
    wr(4'd11, 16'h0300);
    chk("R2 clear slow subset", clkEn, expClk());
    rd(4'd9, "R2 status after clear");
    wr(4'd7, 16'h00F0);
    chk("R2 clear fast subset", clkEn, expClk());

    // R6 and R5: clear everything in slow group
    wr(4'd11, 16'hFFFF);
    chk("R6 console kept after clear", {47'h0, clkEn[33]}, 48'h1);
    chk("R5 absent line on", {47'h0, clkEn[38]}, 48'h1);
    rd(4'd9, "R6 slow status after full clear");

    // R4 hardware-owned lines
    wr(4'd2, 16'h0018);
    chk("R4 hw lines ignore set", {46'h0, clkEn[4:3]}, 48'h0);
    @(negedge clk);
    hwClkReq = {16'h0001, 16'h0000, 16'h0010};
    @(negedge clk);
    chk("R4 hw lines follow request", clkEn, expClk());
    wr(4'd3, 16'h0010);
    chk("R4 hw line ignores clear", {47'h0, clkEn[4]}, 48'h1);
    rd(4'd1, "R4 status with hw request");

    // R10 unmapped and write-only offsets
    wr(4'd13, 16'hFFFF);
    wr(4'd1, 16'hFFFF);
    chk("R10 writes ignored clkEn", clkEn, expClk());
    chk("R10 writes ignored periphRst", periphRst, {mRst[2], mRst[1], mRst[0]});
    rd(4'd12, "R10 unmapped read");
    rd(4'd15, "R10 unmapped read");
    rd(4'd2, "R10 set offset read");
    rd(4'd7, "R10 clear offset read");

    // R11 hold without a read strobe
    rd(4'd8, "R11 read before hold");
    held = mRst[2];
    wr(4'd8, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R11 rdData holds", {32'h0, rdData}, {32'h0, held});
    rd(4'd8, "R11 new value read");

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule